// File: doc/BRIEF.md
# Keyed Protect-Mode Register Guard

This block sits on a simple peripheral write port and guards one 8-bit protect mode register that decides which flash regions are shielded. The register cannot be changed by a single store. Software must first store a key byte to a command register. It then makes three stores in a row to the mode register: the new value, its bitwise inverse, and the new value again. Only when all three match does the register take the new value. If another peripheral register is stored to during the sequence, or a data byte does not match, the sequence is dropped, a sticky sequence error flag is raised and the mode register keeps its old value.

The block also holds an 8-bit status register with three sticky error flags. The first is the sequence error. The second is a verify error, raised by an erase-verify or write-verify failure. The third is a protect error, raised by a command aimed at a protected area or by an attempt to program a 1 into a bit that still holds 0. Software clears a flag by storing 0 to its bit. The flash array, the programming engine and the comparison of addresses against the protect byte are outside this block; their results arrive as input pulses.

Top module: `keyed_prot_guard`

## Requirements
- R1: After reset the status output is 0x00 and the mode output equals parameter MODE_RST.
- R2: A store of KEY (0xA5) to CMD_ADDR, followed by stores of v, ~v and v to MODE_ADDR with no other store in between, makes the mode output equal v from the cycle after the last store. The status register is not changed.
- R3: After the key, a store to any address other than MODE_ADDR aborts the sequence and sets status bit 0. The mode output is not changed. Later stores to MODE_ADDR are ignored until a new key store.
- R4: A second store that is not the inverse of the first value, or a third store that differs from the first value, sets status bit 0 and leaves the mode output unchanged.
- R5: A store to MODE_ADDR with no sequence in progress is ignored. A store to CMD_ADDR with a value other than KEY does not start a sequence.
- R6: A verify_fail pulse sets status bit 1.
- R7: A prot_viol pulse sets status bit 2. When VERR_ON_PERR is 1 it also sets status bit 1.
- R8: A prog_valid cycle in which prog_data has a 1 where cell_data has a 0 sets status bit 2 (and bit 1 when VERR_ON_PERR is 1). A prog_valid cycle without such a bit sets nothing.
- R9: A store to STAT_ADDR clears each of bits 2..0 whose written data bit is 0 and leaves each whose data bit is 1. Status bits 7..3 always read 0.
- R10: If a flag's set event and its software clear fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Store strobe on the peripheral port |
| wr_addr | input | ADDR_W | Store address |
| wr_data | input | 8 | Store data |
| verify_fail | input | 1 | Pulse: erase-verify or write-verify failure |
| prot_viol | input | 1 | Pulse: command aimed at a protected area |
| prog_valid | input | 1 | A program operation is presented on prog_data/cell_data |
| prog_data | input | 8 | Byte being programmed |
| cell_data | input | 8 | Present contents of the target byte |
| mode_q | output | 8 | Protect mode register |
| status_q | output | 8 | Status register {5'b0, protect err, verify err, sequence err} |

## Verification
The bench is built with ADDR_W=8, CMD_ADDR=0xA0, MODE_ADDR=0xA1, STAT_ADDR=0xA2, MODE_RST=0x00 and VERR_ON_PERR=1. The defaults reach both the commit path and every kind of abort, including an abort caused by a store to the status register itself, where the sequence error and a software clear of the same bit fall in one cycle. With VERR_ON_PERR set to 1, the bench can observe that protect errors also raise the verify flag.

// File: rtl/kpg_pkg.sv
package kpg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_VAL   = 2'd1,
    ST_INV   = 2'd2,
    ST_AGAIN = 2'd3
  } seq_state_t;
  localparam int unsigned FLAG_SEQ  = 0;
  localparam int unsigned FLAG_VER  = 1;
  localparam int unsigned FLAG_PROT = 2;
  localparam int unsigned NFLAGS    = 3;
endpackage

// File: rtl/kpg_rst_sync.sv
module kpg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/kpg_seq_fsm.sv
module kpg_seq_fsm
  import kpg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [7:0]  KEY       = 8'hA5,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'hA0,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'hA1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              commit,
  output logic [7:0]        commit_val,
  output logic              abort
);
  seq_state_t state_q, state_d;
  logic [7:0] val_q, val_d;
  logic       val_en;
  logic       to_mode;

  assign to_mode = wr_en && (wr_addr == MODE_ADDR);

  always_comb begin
    state_d = state_q;
    val_d   = wr_data;
    val_en  = 1'b0;
    commit  = 1'b0;
    abort   = 1'b0;
    if (wr_en) begin
      unique case (state_q)
        ST_IDLE: if (wr_addr == CMD_ADDR && wr_data == KEY) state_d = ST_VAL;
        ST_VAL: begin
          if (to_mode) begin
            val_en  = 1'b1;
            state_d = ST_INV;
          end else begin
            abort   = 1'b1;
            state_d = ST_IDLE;
          end
        end
        ST_INV: begin
          if (to_mode && wr_data == ~val_q) state_d = ST_AGAIN;
          else begin
            abort   = 1'b1;
            state_d = ST_IDLE;
          end
        end
        ST_AGAIN: begin
          if (to_mode && wr_data == val_q) commit = 1'b1;
          else abort = 1'b1;
          state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign commit_val = val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      val_q   <= '0;
    end else begin
      state_q <= state_d;
      if (val_en) val_q <= val_d;
    end
  end

  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && abort));
  p_idle_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (abort || commit) |=> (state_q == ST_IDLE));
  p_noabort_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !abort && !commit);
endmodule

// File: rtl/kpg_status.sv
module kpg_status
  import kpg_pkg::*;
#(
  parameter bit VERR_ON_PERR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_err,
  input  logic              verify_fail,
  input  logic              prot_viol,
  input  logic              prog_valid,
  input  logic [7:0]        prog_data,
  input  logic [7:0]        cell_data,
  input  logic              clr_en,
  input  logic [NFLAGS-1:0] clr_data,
  output logic [7:0]        status_q
);
  logic [NFLAGS-1:0] flag_q, flag_d, set_v, clr_v;
  logic              overwrite, perr;

  assign overwrite = prog_valid && |(prog_data & ~cell_data);
  assign perr      = prot_viol || overwrite;

  always_comb begin
    set_v            = '0;
    set_v[FLAG_SEQ]  = seq_err;
    set_v[FLAG_PROT] = perr;
    set_v[FLAG_VER]  = verify_fail || (VERR_ON_PERR && perr);
    clr_v            = clr_en ? ~clr_data : '0;
    flag_d           = (flag_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign status_q = {{(8-NFLAGS){1'b0}}, flag_q};

  p_hi_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[7:NFLAGS] == '0);
  p_verify_r6: assert property (@(posedge clk) disable iff (!rst_n)
    verify_fail |=> status_q[FLAG_VER]);
  p_prot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prot_viol |=> status_q[FLAG_PROT]);
  p_setwins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> status_q[FLAG_SEQ]);
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[FLAG_SEQ] && !clr_en) |=> status_q[FLAG_SEQ]);
endmodule

// File: rtl/keyed_prot_guard.sv
module keyed_prot_guard
  import kpg_pkg::*;
#(
  parameter int unsigned       ADDR_W       = 8,
  parameter logic [7:0]        KEY          = 8'hA5,
  parameter logic [ADDR_W-1:0] CMD_ADDR     = 8'hA0,
  parameter logic [ADDR_W-1:0] MODE_ADDR    = 8'hA1,
  parameter logic [ADDR_W-1:0] STAT_ADDR    = 8'hA2,
  parameter logic [7:0]        MODE_RST     = 8'h00,
  parameter bit                VERR_ON_PERR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              verify_fail,
  input  logic              prot_viol,
  input  logic              prog_valid,
  input  logic [7:0]        prog_data,
  input  logic [7:0]        cell_data,
  output logic [7:0]        mode_q,
  output logic [7:0]        status_q
);
  logic       rst_i_n;
  logic       commit, abort;
  logic [7:0] commit_val;
  logic       clr_en;

  kpg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  kpg_seq_fsm #(
    .ADDR_W(ADDR_W), .KEY(KEY), .CMD_ADDR(CMD_ADDR), .MODE_ADDR(MODE_ADDR)
  ) u_fsm (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit), .commit_val(commit_val), .abort(abort)
  );

  assign clr_en = wr_en && (wr_addr == STAT_ADDR);

  kpg_status #(.VERR_ON_PERR(VERR_ON_PERR)) u_stat (
    .clk(clk), .rst_n(rst_i_n), .seq_err(abort),
    .verify_fail(verify_fail), .prot_viol(prot_viol),
    .prog_valid(prog_valid), .prog_data(prog_data), .cell_data(cell_data),
    .clr_en(clr_en), .clr_data(wr_data[NFLAGS-1:0]), .status_q(status_q)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    mode_q <= MODE_RST;
    else if (commit) mode_q <= commit_val;
  end

  p_abort_keeps_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    abort |=> $stable(mode_q));
  p_commit_val_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (commit && wr_data == commit_val) |=> (mode_q == $past(wr_data)));
  p_nostore_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    !wr_en |=> $stable(mode_q));
endmodule

// File: tb/tb_keyed_prot_guard.sv
module tb_keyed_prot_guard;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CMD = 8'hA0, MODE = 8'hA1, STAT = 8'hA2, OTHER = 8'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic verify_fail = 1'b0, prot_viol = 1'b0, prog_valid = 1'b0;
  logic [7:0] prog_data = '0, cell_data = '0;
  logic [7:0] mode_q, status_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_prot_guard dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .verify_fail(verify_fail), .prot_viol(prot_viol), .prog_valid(prog_valid),
    .prog_data(prog_data), .cell_data(cell_data), .mode_q(mode_q), .status_q(status_q)
  );

  typedef struct { string tag; logic [7:0] st; logic [7:0] md; } exp_t;
  exp_t sb[$];
  int n_run = 0, n_fail = 0;

  int         m_step = 0;
  logic [7:0] m_val = 0, m_mode = 0, m_stat = 0;

  task automatic check(string tag, logic [7:0] st, logic [7:0] md);
    n_run++;
    if (status_q !== st || mode_q !== md) begin
      n_fail++;
      $display("FAIL %s: status=%h mode=%h expected status=%h mode=%h",
               tag, status_q, mode_q, st, md);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, e.st, e.md);
    end
  end

  task automatic store(logic [7:0] a, logic [7:0] d, string tag);
    logic ab;
    logic [7:0] clr;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    ab = 1'b0;
    case (m_step)
      0: if (a == CMD && d == 8'hA5) m_step = 1;
      1: if (a == MODE) begin m_val = d; m_step = 2; end else begin ab = 1; m_step = 0; end
      2: if (a == MODE && d == ~m_val) m_step = 3; else begin ab = 1; m_step = 0; end
      default: begin
        if (a == MODE && d == m_val) m_mode = m_val; else ab = 1;
        m_step = 0;
      end
    endcase
    clr = (a == STAT) ? {5'b0, ~d[2:0]} : 8'h00;
    m_stat = (m_stat & ~clr) | {7'b0, ab};
    sb.push_back('{tag, m_stat, m_mode});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic event_in(logic vf, logic pv, logic pg, logic [7:0] pd, logic [7:0] cd, string tag);
    logic pe;
    @(negedge clk);
    verify_fail = vf; prot_viol = pv; prog_valid = pg; prog_data = pd; cell_data = cd;
    pe = pv | (pg & |(pd & ~cd));
    m_stat = m_stat | {5'b0, pe, vf | pe, 1'b0};
    sb.push_back('{tag, m_stat, m_mode});
    @(negedge clk);
    verify_fail = 0; prot_viol = 0; prog_valid = 0;
  endtask

  task automatic unlock(logic [7:0] v, string tag);
    store(CMD, 8'hA5, tag); store(MODE, v, tag); store(MODE, ~v, tag); store(MODE, v, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset", 8'h00, 8'h00);
    // R2 good sequences
    unlock(8'h3C, "R2 commit 3C");
    unlock(8'hFF, "R2 commit FF");
    unlock(8'h00, "R2 commit 00");
    // R5 ignored stores
    store(MODE, 8'h77, "R5 mode store idle");
    store(CMD, 8'h5A, "R5 bad key");
    store(MODE, 8'h12, "R5 after bad key");
    store(MODE, 8'hED, "R5 after bad key 2");
    store(MODE, 8'h12, "R5 after bad key 3");
    // R3 abort by foreign store
    store(CMD, 8'hA5, "R3 key");
    store(MODE, 8'h55, "R3 value");
    store(OTHER, 8'h01, "R3 foreign store");
    store(MODE, 8'hAA, "R3 stale inverse");
    store(MODE, 8'h55, "R3 stale repeat");
    store(STAT, 8'h00, "R9 clear all");
    // R3 key store in middle aborts
    store(CMD, 8'hA5, "R3 key2");
    store(CMD, 8'hA5, "R3 key instead of value");
    store(STAT, 8'hFE, "R9 clear bit0");
    // R4 wrong inverse / wrong repeat
    store(CMD, 8'hA5, "R4 key");
    store(MODE, 8'h81, "R4 val");
    store(MODE, 8'h7F, "R4 bad inverse");
    store(STAT, 8'h06, "R9 clear bit0 keep");
    store(CMD, 8'hA5, "R4 key b");
    store(MODE, 8'h81, "R4 val b");
    store(MODE, 8'h7E, "R4 inverse b");
    store(MODE, 8'h80, "R4 bad repeat");
    // R10 status store during sequence: abort set wins over clear
    store(STAT, 8'h00, "R9 clear");
    store(CMD, 8'hA5, "R10 key");
    store(MODE, 8'h42, "R10 val");
    store(STAT, 8'h00, "R10 set wins");
    // R6..R8
    store(STAT, 8'h00, "R9 clear");
    event_in(1, 0, 0, 8'h00, 8'h00, "R6 verify fail");
    store(STAT, 8'h00, "R9 clear");
    event_in(0, 1, 0, 8'h00, 8'h00, "R7 protect viol");
    store(STAT, 8'hFB, "R9 clear bit2 only");
    store(STAT, 8'h00, "R9 clear");
    event_in(0, 0, 1, 8'h0F, 8'hFF, "R8 no overwrite");
    event_in(0, 0, 1, 8'h10, 8'hEF, "R8 overwrite");
    store(STAT, 8'hFF, "R9 write ones no effect");
    store(STAT, 8'h00, "R9 clear");
    unlock(8'hC3, "R2 commit after errors");
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule